// File: doc/BRIEF.md
# Busy-Polling Display Command Sequencer

This block is the host-side engine that talks to a character display controller over an 8-bit parallel bus. A user-side agent hands it one request at a time through a valid/ready pair. Each request is either an instruction byte or a display data byte. The controller rejects every access except its status read while it is working on an earlier command. For that reason the sequencer never writes blindly. Before every write it reads the controller's status byte. It repeats that read until the busy bit comes back clear.

A status read drives the register-select line low and the read/write line high. It pulses the enable strobe and captures the returned byte on the final strobe cycle, which is the cycle in which enable falls. Bit 7 of that byte is the busy flag and bits 6:0 are the controller's address counter. When the busy bit is clear, the sequencer publishes the address counter on its own output with a one-cycle valid pulse. It then writes the request: register-select is low for an instruction and high for data. A bounded number of polls protects against a controller that never goes idle. If that many reads all return busy, the request is dropped and a sticky timeout flag is raised.

Top module: `lcd_cmd_sequencer`

## Requirements
- R1: No write strobe occurs unless the status read just before it returned bit 7 (busy) = 0; while bit 7 = 1 the status read is repeated, so a request facing N busy reads (N < POLL_LIMIT) sees exactly N+1 status reads and then one write.
- R2: A status read drives bus_rs=0, bus_rw=1, bus_oe=0, and the block takes bus_din on the last cycle that bus_en is high; bit 7 is the busy flag and bits 6:0 are the address counter.
- R3: An instruction request (req_is_data=0) is written with bus_rs=0, bus_rw=0; a data request (req_is_data=1) with bus_rs=1, bus_rw=0; in both cases bus_oe=1 and bus_dout equals the request byte while bus_en is high.
- R4: Before every rise of bus_en, bus_rs and bus_rw have held steady with bus_en low for at least SETUP_CYC cycles, and bus_en stays high for exactly STROBE_CYC cycles.
- R5: req_ready is high only while the sequencer is idle; after a request is taken it stays low until that request has been written or dropped.
- R6: After a status read with busy = 0, addr_out holds bits 6:0 of that read, and addr_valid is high for exactly one cycle; addr_out is unchanged otherwise.
- R7: If POLL_LIMIT status reads in a row return busy = 1, the request is dropped with no write and no addr_valid pulse, and timeout_flag goes high and stays high until reset, even across later successful requests.
- R8: After reset: req_ready=1, bus_en=0, bus_rs=0, bus_rw=1, bus_oe=0, addr_out=0, addr_valid=0, timeout_flag=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Sequencer can take a request (idle) |
| req_is_data | input | 1 | 1 = data byte, 0 = instruction byte |
| req_byte | input | 8 | Byte to write |
| bus_rs | output | 1 | Register-select line to the controller |
| bus_rw | output | 1 | Read/write line, 1 = read |
| bus_en | output | 1 | Enable strobe |
| bus_oe | output | 1 | Host drives the data bus when high |
| bus_dout | output | 8 | Data bus value driven by the host |
| bus_din | input | 8 | Data bus value returned by the controller |
| addr_out | output | 7 | Address counter from the last successful status read |
| addr_valid | output | 1 | One-cycle pulse when addr_out is refreshed |
| timeout_flag | output | 1 | Sticky: a request was dropped after too many busy reads |

## Verification
The controller model in the bench answers a set number of busy reads per request and then reports idle. Requests mix instructions and data bytes, use address values across the 7-bit range, and face busy counts of zero, a few, one below the limit, and exactly the limit. The zero and small counts show whether the sequencer polls once or loops. The count one below the limit separates a correct bound from an off-by-one timeout. The count equal to the limit shows that the request is dropped, with no write and no address pulse. A successful request after a timeout, and then a reset, show whether the timeout flag is sticky and how it is cleared.

// File: rtl/lcdseq_pkg.sv
// Package: shared state encoding and status-byte field positions for the
// display command sequencer. Assumes an 8-bit status byte, busy in bit 7.
package lcdseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL_SETUP,
        ST_POLL_STROBE,
        ST_POLL_CHECK,
        ST_WRITE_SETUP,
        ST_WRITE_STROBE,
        ST_DONE
    } seq_state_e;

    localparam int STATUS_BUSY_BIT = 7;
    localparam int ADDR_W          = 7;
endpackage

// File: rtl/lcdseq_phase_timer.sv
// Module: counts clock cycles spent in the current bus phase.
// Assumes the owner pulses clear on every state change; the count never
// needs to exceed the longest phase, which the owner bounds.
module lcdseq_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    output logic [CW-1:0] count
);
    // Restart on clear, otherwise advance by one each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) count <= '0;
        else                 count <= count + 1'b1;
    end
endmodule

// File: rtl/lcdseq_poll_limiter.sv
// Module: counts busy status reads for the current request and reports when
// the last allowed read has been used. Assumes arm is held while idle and
// tick pulses once per busy read that does not time out.
module lcdseq_poll_limiter #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic tick,
    output logic at_limit
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [CW-1:0] busy_reads;

    // Count busy reads since the request was taken.
    always_ff @(posedge clk) begin
        if (!rst_n || arm)           busy_reads <= '0;
        else if (tick && !at_limit)  busy_reads <= busy_reads + 1'b1;
    end

    assign at_limit = (busy_reads == CW'(LIMIT - 1));

    AST_LIMIT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        at_limit && !arm |=> at_limit || $past(arm)); // R7
endmodule

// File: rtl/lcd_cmd_sequencer.sv
// Module: host-side sequencer for a character display controller on an
// 8-bit parallel bus. Each accepted request is preceded by repeated status
// reads until the busy bit is clear, then written with an enable strobe.
// Assumes bus_din is valid on the last cycle of each read strobe.
module lcd_cmd_sequencer
    import lcdseq_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 3,
    parameter int POLL_LIMIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_data,
    input  logic [7:0]        req_byte,
    output logic              bus_rs,
    output logic              bus_rw,
    output logic              bus_en,
    output logic              bus_oe,
    output logic [7:0]        bus_dout,
    input  logic [7:0]        bus_din,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_valid,
    output logic              timeout_flag
);
    localparam int PH_MAX = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int PH_W   = $clog2(PH_MAX + 1);

    seq_state_e        state_q, state_d;
    logic              is_data_q;
    logic [7:0]        byte_q;
    logic [7:0]        status_q;
    logic [PH_W-1:0]   phase_cnt;
    logic              setup_last, strobe_last;
    logic              poll_at_limit;
    logic              status_busy;
    logic              writing;

    lcdseq_phase_timer #(.CW(PH_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_d != state_q),
        .count (phase_cnt)
    );

    lcdseq_poll_limiter #(.LIMIT(POLL_LIMIT)) u_limit (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (state_q == ST_IDLE),
        .tick     (state_q == ST_POLL_CHECK && status_busy && !poll_at_limit),
        .at_limit (poll_at_limit)
    );

    assign setup_last  = (phase_cnt == PH_W'(SETUP_CYC - 1));
    assign strobe_last = (phase_cnt == PH_W'(STROBE_CYC - 1));
    assign status_busy = status_q[STATUS_BUSY_BIT];

    // Next-state selection for the poll-then-write sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:         if (req_valid)   state_d = ST_POLL_SETUP;
            ST_POLL_SETUP:   if (setup_last)  state_d = ST_POLL_STROBE;
            ST_POLL_STROBE:  if (strobe_last) state_d = ST_POLL_CHECK;
            ST_POLL_CHECK: begin
                if (!status_busy)       state_d = ST_WRITE_SETUP;
                else if (poll_at_limit) state_d = ST_IDLE;
                else                    state_d = ST_POLL_SETUP;
            end
            ST_WRITE_SETUP:  if (setup_last)  state_d = ST_WRITE_STROBE;
            ST_WRITE_STROBE: if (strobe_last) state_d = ST_DONE;
            ST_DONE:                          state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_data_q <= 1'b0;
            byte_q    <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            is_data_q <= req_is_data;
            byte_q    <= req_byte;
        end
    end

    // Sample the status byte on the cycle the read strobe falls.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     status_q <= '0;
        else if (state_q == ST_POLL_STROBE && strobe_last) status_q <= bus_din;
    end

    // Publish the address counter from a status read with busy clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out   <= '0;
            addr_valid <= 1'b0;
        end else begin
            addr_valid <= (state_q == ST_POLL_CHECK) && !status_busy;
            if (state_q == ST_POLL_CHECK && !status_busy)
                addr_out <= status_q[ADDR_W-1:0];
        end
    end

    // Sticky timeout when the poll budget runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) timeout_flag <= 1'b0;
        else if (state_q == ST_POLL_CHECK && status_busy && poll_at_limit)
            timeout_flag <= 1'b1;
    end

    // Bus pin levels derived from the current phase.
    assign writing   = (state_q == ST_WRITE_SETUP) || (state_q == ST_WRITE_STROBE)
                    || (state_q == ST_DONE);
    assign bus_en    = (state_q == ST_POLL_STROBE) || (state_q == ST_WRITE_STROBE);
    assign bus_rw    = !writing;
    assign bus_rs    = writing && is_data_q;
    assign bus_oe    = writing;
    assign bus_dout  = byte_q;
    assign req_ready = (state_q == ST_IDLE);

    AST_WRITE_NEEDS_IDLE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en && !bus_rw |-> !status_q[STATUS_BUSY_BIT]); // R1
    AST_READ_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en && bus_rw |-> !bus_oe && !bus_rs); // R2
    AST_STROBE_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_en) |-> $stable(bus_rs) && $stable(bus_rw)); // R4
    AST_READY_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_en && !bus_oe); // R5
    AST_ADDR_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> !addr_valid); // R6
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> $stable(addr_out) || $past(!rst_n)); // R6
    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |=> timeout_flag); // R7
endmodule

// File: tb/lcd_cmd_sequencer_bench.sv
module lcd_cmd_sequencer_bench;
    localparam int SETUP  = 2;
    localparam int STROBE = 3;
    localparam int LIMIT  = 5;
    localparam int NVEC   = 6;
    // {is_data, byte, busy_reads, address}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 8'h01, 4'd0, 7'h00},
        {1'b1, 8'h41, 4'd2, 7'h05},
        {1'b0, 8'hC0, 4'd1, 7'h40},
        {1'b1, 8'hFF, 4'd4, 7'h7F},
        {1'b1, 8'h00, 4'd3, 7'h2A},
        {1'b0, 8'h38, 4'd5, 7'h11}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_is_data = 1'b0;
    logic [7:0] req_byte = '0;
    logic req_ready, bus_rs, bus_rw, bus_en, bus_oe, addr_valid, timeout_flag;
    logic [7:0] bus_dout, bus_din;
    logic [6:0] addr_out;

    int checks = 0, errors = 0;
    int cur_busy = 0;
    logic [6:0] cur_ac = '0;
    int reads_seen = 0, writes_seen = 0, pulses = 0;
    logic wr_rs = 1'b0, wr_oe = 1'b0;
    logic [7:0] wr_byte = '0;
    logic prev_en = 1'b0, prev_rs = 1'b0, prev_rw = 1'b1;
    int setup_run = 0, high_run = 0;

    always #4 clk = ~clk;

    assign bus_din = {(reads_seen < cur_busy), cur_ac};

    lcd_cmd_sequencer #(.SETUP_CYC(SETUP), .STROBE_CYC(STROBE), .POLL_LIMIT(LIMIT))
    u_lcd_cmd_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_data(req_is_data), .req_byte(req_byte), .bus_rs(bus_rs),
        .bus_rw(bus_rw), .bus_en(bus_en), .bus_oe(bus_oe), .bus_dout(bus_dout),
        .bus_din(bus_din), .addr_out(addr_out), .addr_valid(addr_valid),
        .timeout_flag(timeout_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Bus monitor: setup/strobe timing, read and write bookkeeping.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!bus_en) begin
                if (!prev_en && bus_rs == prev_rs && bus_rw == prev_rw) setup_run++;
                else setup_run = 1;
            end
            if (bus_en && !prev_en)
                chk(setup_run >= SETUP && bus_rs == prev_rs && bus_rw == prev_rw,
                    "R4 setup", setup_run, SETUP);
            if (bus_en) high_run++;
            if (!bus_en && prev_en) begin
                chk(high_run == STROBE, "R4 strobe width", high_run, STROBE);
                high_run = 0;
                if (prev_rw) begin
                    reads_seen++;
                end else begin
                    writes_seen++;
                    chk(reads_seen == cur_busy + 1, "R1 polls before write", reads_seen, cur_busy + 1);
                end
            end
            if (bus_en && bus_rw)
                chk(!bus_rs && !bus_oe, "R2 read levels", {bus_rs, bus_oe}, 0);
            if (bus_en && !bus_rw) begin
                wr_rs = bus_rs; wr_oe = bus_oe; wr_byte = bus_dout;
            end
            if (addr_valid) pulses++;
        end
        prev_en = bus_en; prev_rs = bus_rs; prev_rw = bus_rw;
    end

    task automatic run_req(input logic is_data, input logic [7:0] b, input int busy,
                           input logic [6:0] ac, input bit exp_to);
        logic [6:0] addr_before;
        bit ok_path;
        ok_path = (busy < LIMIT);
        addr_before = addr_out;
        cur_busy = busy; cur_ac = ac;
        reads_seen = 0; writes_seen = 0; pulses = 0;
        @(negedge clk);
        req_valid = 1'b1; req_is_data = is_data; req_byte = b;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R5 ready low while busy", req_ready, 0);
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        if (ok_path) begin
            chk(reads_seen == busy + 1, "R1 status reads", reads_seen, busy + 1);
            chk(writes_seen == 1, "R1 one write", writes_seen, 1);
            chk(wr_rs == is_data && wr_oe, "R3 write levels", {wr_rs, wr_oe}, {is_data, 1'b1});
            chk(wr_byte == b, "R3 write byte", wr_byte, b);
            chk(addr_out == ac, "R2 R6 address", addr_out, ac);
            chk(pulses == 1, "R6 valid pulse count", pulses, 1);
        end else begin
            chk(reads_seen == LIMIT, "R7 reads before timeout", reads_seen, LIMIT);
            chk(writes_seen == 0, "R7 no write", writes_seen, 0);
            chk(pulses == 0, "R7 no pulse", pulses, 0);
            chk(addr_out == addr_before, "R7 address kept", addr_out, addr_before);
        end
        chk(timeout_flag == exp_to, "R7 timeout flag", timeout_flag, exp_to);
    endtask

    task automatic check_reset_state();
        chk(req_ready && !bus_en && !bus_rs && bus_rw && !bus_oe, "R8 bus and ready",
            {req_ready, bus_en, bus_rs, bus_rw, bus_oe}, 5'b10010);
        chk(addr_out == 0 && !addr_valid && !timeout_flag, "R8 outputs",
            {addr_out, addr_valid, timeout_flag}, 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();
        for (int i = 0; i < NVEC; i++)
            run_req(VEC[i][19], VEC[i][18:11], int'(VEC[i][10:7]), VEC[i][6:0],
                    (i == NVEC - 1));
        // R7: flag stays set through a later successful request.
        run_req(1'b1, 8'h5A, 0, 7'h33, 1'b1);
        // R8: reset clears the sticky flag and the address.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();
        run_req(1'b0, 8'h0C, 1, 7'h01, 1'b0);
        finish_run();
    end
endmodule